// File: doc/BRIEF.md
# MII to RMII Interface Adapter

This block sits between the 4-bit nibble transmit and receive paths of an Ethernet MAC and an external PHY. One mode input picks the PHY interface. When the input is clear, every MAC signal is wired straight through to a full-width MII PHY. When it is set, the adapter drives a reduced-pin RMII PHY. In that mode it splits each transmit nibble into two 2-bit symbols. On receive it rebuilds nibbles from incoming symbols and marks each one with a strobe.

In RMII mode all logic runs on the single reference clock. A speed input chooses between two symbol rates. At 100 Mb/s one symbol moves every clock. At 10 Mb/s one symbol moves every `SLOW_DIV` clocks.

The PHY reports carrier and receive-data-valid together on one pin. The adapter recovers carrier sense directly from that pin. It derives receive data valid from its own lock onto the incoming preamble. Nibble alignment begins at the first non-zero symbol seen while the shared pin is high.

Top module: `mii_rmii_bridge`

## Requirements
- R1: With `rmii_mode` low, the outputs follow the inputs combinationally: `phy_txd`/`phy_txen`/`phy_txer` follow `mac_txd`/`mac_txen`/`mac_txer`, `mac_rxd`/`mac_rxdv`/`mac_rxer`/`mac_crs`/`mac_col` follow `phy_rxd`/`phy_rxdv`/`phy_rxer`/`phy_crsdv`/`phy_col`, `mac_tx_take` is 1, and `mac_rx_stb` equals `phy_rxdv`.
- R2: With `rmii_mode` high and `speed_100` high, a nibble offered with `mac_txen` high while `mac_tx_take` is 1 appears on `phy_txd[1:0]` one clock later as bits [1:0]. Bits [3:2] follow on the next clock. `phy_txd[3:2]` stays 0, and `phy_txen` is high for both symbols.
- R3: In RMII mode, `mac_col` reads 0 and `phy_txer` is driven 0, whatever `phy_col` and `mac_txer` are.
- R4: In RMII mode, the receiver ignores zero-valued symbols while `phy_crsdv` is high and unlocked, and `mac_rxdv` stays 0 during that time. The first non-zero symbol on `phy_rxd[1:0]` sets `mac_rxdv` and is taken as the low half of a nibble.
- R5: After lock, each pair of received symbols produces a nibble on `mac_rxd`. The first symbol becomes bits [1:0] and the second becomes bits [3:2]. `mac_rx_stb` pulses for exactly one clock with that nibble.
- R6: In RMII mode, `mac_rxer` is set along with a strobed nibble if `phy_rxer` was high during either of its two symbols. Otherwise it is 0.
- R7: With `speed_100` low in RMII mode, each transmitted symbol is held for `SLOW_DIV` clocks. The receiver samples `phy_rxd` once every `SLOW_DIV` clocks.
- R8: In RMII mode, `mac_crs` follows `phy_crsdv`. A sample with `phy_crsdv` low drops `mac_rxdv` and the lock.
- R9: While `rst_n` is low in RMII mode, `phy_txen`, `mac_rxdv` and `mac_rx_stb` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (RMII) |
| rst_n | input | 1 | Active-low reset |
| rmii_mode | input | 1 | 1 selects RMII, 0 selects MII pass-through |
| speed_100 | input | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| mac_txd | input | 4 | Transmit nibble from MAC |
| mac_txen | input | 1 | Transmit enable from MAC |
| mac_txer | input | 1 | Transmit error from MAC |
| mac_tx_take | output | 1 | Nibble on `mac_txd` is accepted this clock |
| mac_rxd | output | 4 | Receive nibble to MAC |
| mac_rxdv | output | 1 | Receive data valid to MAC |
| mac_rxer | output | 1 | Receive error to MAC |
| mac_rx_stb | output | 1 | New receive nibble strobe |
| mac_crs | output | 1 | Carrier sense to MAC |
| mac_col | output | 1 | Collision to MAC |
| phy_txd | output | 4 | Transmit data to PHY (bits [1:0] in RMII) |
| phy_txen | output | 1 | Transmit enable to PHY |
| phy_txer | output | 1 | Transmit error to PHY |
| phy_rxd | input | 4 | Receive data from PHY (bits [1:0] in RMII) |
| phy_rxdv | input | 1 | Receive data valid from PHY (MII) |
| phy_rxer | input | 1 | Receive error from PHY |
| phy_crsdv | input | 1 | Carrier sense (MII) or shared carrier/valid pin (RMII) |
| phy_col | input | 1 | Collision from PHY (MII) |

## Verification
The bench builds the adapter with the default `SLOW_DIV` of 10. This keeps a 10 Mb/s symbol short enough to measure its hold time clock by clock, and to confirm that a receive symbol held for exactly ten clocks is sampled once. Most receive patterns run at 100 Mb/s, where every clock is a sample. At that rate the preamble lock, symbol order and per-nibble error marking can each be checked at a known cycle.

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge #(
  parameter int SLOW_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rmii_mode,
  input  logic       speed_100,
  input  logic [3:0] mac_txd,
  input  logic       mac_txen,
  input  logic       mac_txer,
  output logic       mac_tx_take,
  output logic [3:0] mac_rxd,
  output logic       mac_rxdv,
  output logic       mac_rxer,
  output logic       mac_rx_stb,
  output logic       mac_crs,
  output logic       mac_col,
  output logic [3:0] phy_txd,
  output logic       phy_txen,
  output logic       phy_txer,
  input  logic [3:0] phy_rxd,
  input  logic       phy_rxdv,
  input  logic       phy_rxer,
  input  logic       phy_crsdv,
  input  logic       phy_col
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] div_q;
  logic          tick;

  logic       tx_phase, tx_en_q;
  logic [1:0] tx_hi_q, tx_sym_q;

  logic       rx_lock, rx_phase, rx_err_lo, rx_err_q, rx_stb_q;
  logic [1:0] rx_lo_q;
  logic [3:0] rx_nib_q;

  wire [1:0] sym_in = phy_rxd[1:0];

  assign tick = speed_100 || (div_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        div_q <= '0;
    else if (speed_100 || div_q == LAST) div_q <= '0;
    else                               div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_phase <= 1'b0;
      tx_en_q  <= 1'b0;
      tx_hi_q  <= 2'b00;
      tx_sym_q <= 2'b00;
    end else if (!rmii_mode) begin
      tx_phase <= 1'b0;
      tx_en_q  <= 1'b0;
    end else if (tick) begin
      if (!tx_phase) begin
        tx_sym_q <= mac_txen ? mac_txd[1:0] : 2'b00;
        tx_hi_q  <= mac_txd[3:2];
        tx_en_q  <= mac_txen;
        tx_phase <= mac_txen;
      end else begin
        tx_sym_q <= tx_hi_q;
        tx_phase <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lock   <= 1'b0;
      rx_phase  <= 1'b0;
      rx_err_lo <= 1'b0;
      rx_err_q  <= 1'b0;
      rx_stb_q  <= 1'b0;
      rx_lo_q   <= 2'b00;
      rx_nib_q  <= 4'h0;
    end else begin
      rx_stb_q <= 1'b0;
      if (!rmii_mode) begin
        rx_lock  <= 1'b0;
        rx_phase <= 1'b0;
      end else if (tick) begin
        if (!phy_crsdv) begin
          rx_lock  <= 1'b0;
          rx_phase <= 1'b0;
        end else if (!rx_lock || !rx_phase) begin
          if (rx_lock || sym_in != 2'b00) begin
            rx_lock   <= 1'b1;
            rx_lo_q   <= sym_in;
            rx_err_lo <= phy_rxer;
            rx_phase  <= 1'b1;
          end
        end else begin
          rx_nib_q <= {sym_in, rx_lo_q};
          rx_err_q <= rx_err_lo | phy_rxer;
          rx_stb_q <= 1'b1;
          rx_phase <= 1'b0;
        end
      end
    end
  end

  assign mac_tx_take = rmii_mode ? (tick && !tx_phase) : 1'b1;
  assign phy_txd     = rmii_mode ? {2'b00, tx_sym_q} : mac_txd;
  assign phy_txen    = rmii_mode ? tx_en_q : mac_txen;
  assign phy_txer    = rmii_mode ? 1'b0 : mac_txer;

  assign mac_rxd     = rmii_mode ? rx_nib_q : phy_rxd;
  assign mac_rxdv    = rmii_mode ? rx_lock : phy_rxdv;
  assign mac_rxer    = rmii_mode ? rx_err_q : phy_rxer;
  assign mac_rx_stb  = rmii_mode ? rx_stb_q : phy_rxdv;
  assign mac_crs     = phy_crsdv;
  assign mac_col     = rmii_mode ? 1'b0 : phy_col;
endmodule

module mii_rmii_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic rmii_mode,
  input logic mac_col,
  input logic phy_txer,
  input logic mac_rx_stb,
  input logic mac_rxdv,
  input logic phy_col,
  input logic mac_txer
);
  p_col_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rmii_mode && phy_col) |-> !mac_col);

  p_txer_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rmii_mode && mac_txer) |-> !phy_txer);

  p_stb_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rmii_mode && mac_rx_stb) |=> (!rmii_mode || !mac_rx_stb));

  p_stb_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rmii_mode && mac_rx_stb) |-> mac_rxdv);
endmodule

bind mii_rmii_bridge mii_rmii_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rmii_mode(rmii_mode), .mac_col(mac_col),
  .phy_txer(phy_txer), .mac_rx_stb(mac_rx_stb), .mac_rxdv(mac_rxdv),
  .phy_col(phy_col), .mac_txer(mac_txer)
);

// File: tb/tb_mii_rmii_bridge.sv
module tb_mii_rmii_bridge;
  logic clk = 1'b0, rst_n = 1'b0, rmii_mode = 1'b1, speed_100 = 1'b1;
  logic [3:0] mac_txd = 4'h0, phy_rxd = 4'h0;
  logic mac_txen = 1'b0, mac_txer = 1'b0;
  logic phy_rxdv = 1'b0, phy_rxer = 1'b0, phy_crsdv = 1'b0, phy_col = 1'b0;
  logic mac_tx_take, mac_rxdv, mac_rxer, mac_rx_stb, mac_crs, mac_col;
  logic phy_txen, phy_txer;
  logic [3:0] mac_rxd, phy_txd;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mii_rmii_bridge dut (.*);

  // bits [3:0] nibble, bit 4 error on low symbol, bit 5 error on high symbol
  localparam logic [5:0] RXV [8] = '{6'h05, 6'h05, 6'h0D, 6'h1A,
                                     6'h03, 6'h2C, 6'h0F, 6'h31};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int seen;
    logic [3:0] got;
    logic [1:0] prev;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 txen", phy_txen, 0);
    chk("R9 rxdv", mac_rxdv, 0);
    chk("R9 stb", mac_rx_stb, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4/R5/R6 table-driven receive at 100 Mb/s
    phy_crsdv = 1'b1; phy_rxd = 4'h0;
    repeat (2) begin
      @(negedge clk);
      chk("R4 zero symbols ignored", mac_rxdv, 0);
      chk("R8 crs follows pin", mac_crs, 1);
    end
    for (int i = 0; i < 8; i++) begin
      phy_rxd = {2'b00, RXV[i][1:0]}; phy_rxer = RXV[i][4];
      @(negedge clk);
      chk("R4 lock valid", mac_rxdv, 1);
      chk("R5 strobe low mid-nibble", mac_rx_stb, 0);
      phy_rxd = {2'b00, RXV[i][3:2]}; phy_rxer = RXV[i][5];
      @(negedge clk);
      chk("R5 strobe", mac_rx_stb, 1);
      chk("R5 nibble", mac_rxd, RXV[i][3:0]);
      chk("R6 error mark", mac_rxer, RXV[i][4] | RXV[i][5]);
    end
    phy_rxer = 1'b0;
    phy_crsdv = 1'b0; phy_rxd = 4'h0;
    #1 chk("R8 crs drop", mac_crs, 0);
    @(negedge clk);
    chk("R8 rxdv drop", mac_rxdv, 0);

    // R2 transmit at 100 Mb/s
    chk("R2 take idle", mac_tx_take, 1);
    mac_txen = 1'b1; mac_txd = 4'hA;
    @(negedge clk);
    chk("R2 low symbol", phy_txd, 4'h2);
    chk("R2 txen", phy_txen, 1);
    chk("R2 no take mid", mac_tx_take, 0);
    mac_txd = 4'h3;
    @(negedge clk);
    chk("R2 high symbol", phy_txd, 4'h2);
    chk("R2 take", mac_tx_take, 1);
    @(negedge clk);
    chk("R2 next low", phy_txd, 4'h3);
    mac_txen = 1'b0;
    @(negedge clk);
    chk("R2 next high", phy_txd, 4'h0);
    chk("R2 txen held", phy_txen, 1);
    @(negedge clk);
    chk("R2 txen off", phy_txen, 0);

    // R7 transmit at 10 Mb/s
    speed_100 = 1'b0;
    mac_txd = 4'h6; mac_txen = 1'b1;
    n = 0;
    while (!phy_txen && n < 30) begin @(negedge clk); n++; end
    mac_txd = 4'hE;
    prev = phy_txd[1:0];
    chk("R7 first symbol", prev, 2'b10);
    n = 1;
    @(negedge clk);
    while (phy_txd[1:0] == prev && n < 30) begin n++; @(negedge clk); end
    chk("R7 hold low", n, 10);
    chk("R7 second symbol", phy_txd[1:0], 2'b01);
    prev = phy_txd[1:0]; n = 1;
    @(negedge clk);
    while (phy_txd[1:0] == prev && n < 30) begin n++; @(negedge clk); end
    chk("R7 hold high", n, 10);
    chk("R7 third symbol", phy_txd[1:0], 2'b10);
    mac_txen = 1'b0;
    repeat (25) @(negedge clk);

    // R7 receive at 10 Mb/s
    seen = 0; got = 4'h0;
    phy_crsdv = 1'b1; phy_rxd = 4'h1;
    repeat (10) begin @(negedge clk); if (mac_rx_stb) begin seen++; got = mac_rxd; end end
    phy_rxd = 4'h3;
    repeat (10) begin @(negedge clk); if (mac_rx_stb) begin seen++; got = mac_rxd; end end
    phy_crsdv = 1'b0; phy_rxd = 4'h0;
    repeat (12) begin @(negedge clk); if (mac_rx_stb) begin seen++; got = mac_rxd; end end
    chk("R7 one strobe", seen, 1);
    chk("R7 nibble", got, 4'hD);
    chk("R8 rxdv after drop", mac_rxdv, 0);
    speed_100 = 1'b1;

    // R1 MII pass-through, R3 RMII quiet outputs
    rmii_mode = 1'b0;
    mac_txd = 4'h9; mac_txen = 1'b1; mac_txer = 1'b1;
    phy_rxd = 4'h6; phy_rxdv = 1'b1; phy_rxer = 1'b1; phy_crsdv = 1'b1; phy_col = 1'b1;
    #1;
    chk("R1 txd", phy_txd, 4'h9);
    chk("R1 txen/txer", {phy_txen, phy_txer}, 2'b11);
    chk("R1 rxd", mac_rxd, 4'h6);
    chk("R1 rx ctl", {mac_rxdv, mac_rxer, mac_crs, mac_col, mac_rx_stb, mac_tx_take}, 6'h3F);
    @(negedge clk);
    mac_txen = 1'b0; phy_rxd = 4'h0; phy_rxdv = 1'b0; phy_rxer = 1'b0; phy_crsdv = 1'b0;
    rmii_mode = 1'b1;
    #1;
    chk("R3 col zero", mac_col, 0);
    chk("R3 txer zero", phy_txer, 0);
    repeat (3) @(negedge clk);
    chk("R3 col zero held", mac_col, 0);
    finish_run();
  end
endmodule